// File: doc/BRIEF.md
# Bus-Matching Width Converter with Endian Select

This block sits between the narrow data ports of a FIFO and its 36-bit storage words. The write port and the read port can each be 36, 18 or 9 bits wide. On the write side, successive narrow words are packed into one full storage word, which is handed to the storage array as a single-cycle commit. On the read side, one storage word is taken from the array and handed out as a run of narrow words, one for each accepted read request.

The two port widths and the byte order are sampled while master reset is held and are then frozen. In big-endian order the first narrow word belongs to the most significant lane group of the storage word. In little-endian order it belongs to the least significant group. A partial reset throws away any half-built or half-emptied word but keeps the frozen settings. The storage array and all FIFO flags are outside this block.

Top module: `bus_width_adapter`

## Requirements
- R1: `cfg_in_width`, `cfg_out_width` and `cfg_order` are captured on every clock edge while `mst_rst` is high. Once `mst_rst` is low, changes on these inputs have no effect on packing, unpacking or order.
- R2: A clock edge with `mst_rst` high clears `out_data` to all zeros and drives `out_valid` and `st_wr_en` low.
- R3: The width code is 2'b00 for 36 bits, 2'b01 for 18 bits and 2'b10 for 9 bits. Code 2'b11 behaves as 36 bits. A narrow write uses only the low bits of `in_data` (bits 17:0 or 8:0), and the higher bits are ignored.
- R4: A storage word is committed after 1, 2 or 4 accepted writes (`in_valid` high at a clock edge) for a 36-, 18- or 9-bit write port. `st_wr_en` is high for exactly the one cycle that follows the completing write, and `st_wr_data` holds the assembled word during that cycle.
- R5: With `cfg_order` = 0 (big-endian), narrow word k of a storage word sits in the k-th lane group counted from bit 35 downward. With `cfg_order` = 1 (little-endian), it sits in the k-th group counted from bit 0 upward. For 18-bit words the groups are bits 35:18 and 17:0. For 9-bit words they are 35:27, 26:18, 17:9 and 8:0. Both the write side and the read side follow this order.
- R6: When no word is held, a cycle with `out_ready` and `st_rd_avail` both high asserts `st_rd_take` in that same cycle and fetches `st_rd_data`. The fetched word is then emitted as 1, 2 or 4 narrow words on consecutive accepted `out_ready` cycles. Each narrow word appears on `out_data` together with `out_valid` in the cycle after the request. `st_rd_take` stays low until the last narrow word of the held word has been emitted.
- R7: `out_data` bits above the configured read width are always zero.
- R8: A clock edge with `prt_rst` high discards any partly assembled write word and any held read word, and clears `out_data`. The captured widths and order are kept.
- R9: A cycle with `out_ready` high, no held word and `st_rd_avail` low produces no `st_rd_take`. In the next cycle `out_valid` is low and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mst_rst | input | 1 | Synchronous master reset; captures the configuration |
| prt_rst | input | 1 | Synchronous partial reset; keeps the configuration |
| cfg_in_width | input | 2 | Write port width code, sampled during master reset |
| cfg_out_width | input | 2 | Read port width code, sampled during master reset |
| cfg_order | input | 1 | 0 = big-endian, 1 = little-endian, sampled during master reset |
| in_data | input | 36 | Narrow write word, right-aligned |
| in_valid | input | 1 | Write strobe |
| st_wr_data | output | 36 | Assembled storage word |
| st_wr_en | output | 1 | One-cycle commit of `st_wr_data` |
| st_rd_data | input | 36 | Storage word offered by the array |
| st_rd_avail | input | 1 | A storage word is available to take |
| st_rd_take | output | 1 | Storage word consumed this cycle |
| out_ready | input | 1 | Request for the next narrow read word |
| out_data | output | 36 | Narrow read word, right-aligned, registered |
| out_valid | output | 1 | `out_data` was updated by the last request |

## Verification
The bound checker watches, on every cycle, that the captured configuration never moves outside master reset and that reset leaves zeroed outputs. It also checks that commits and read results only follow a request from the previous cycle, that a fetch never happens without an offered word, and that the unused upper output bits stay zero. Lane placement in both byte orders, the exact write count per commit, and the ordering of narrow reads across a storage word can only be shown by the bench. Its sweep over every pairing of write width, read width and order compares the results with values built arithmetically, and it also covers partial reset, width code 2'b11 and read requests with nothing on offer.

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              mst_rst,
  input  logic              prt_rst,
  input  logic [1:0]        cfg_in_width,
  input  logic [1:0]        cfg_out_width,
  input  logic              cfg_order,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic [WORD_W-1:0] st_wr_data,
  output logic              st_wr_en,
  input  logic [WORD_W-1:0] st_rd_data,
  input  logic              st_rd_avail,
  output logic              st_rd_take,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);

  function automatic int lanes_of(input logic [1:0] code);
    case (code)
      2'b01:   return LANES / 2;
      2'b10:   return LANES / 4;
      default: return LANES;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] seg_mask(input int nl);
    if (nl >= LANES) return '1;
    return (WORD_W'(1) << (nl * LANE_W)) - WORD_W'(1);
  endfunction

  function automatic int seg_shift(input int nl, input int k, input logic le);
    int segs;
    segs = LANES / nl;
    return (le ? k : segs - 1 - k) * nl * LANE_W;
  endfunction

  logic [1:0]        cfg_wr_q, cfg_rd_q;
  logic              order_q;
  logic [WORD_W-1:0] asm_q, hold_q, wr_out_q;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_en_q;

  int                wr_nl, rd_nl, wr_segs, rd_segs;
  logic              wr_last, rd_last, need_fetch, rd_adv;
  logic [WORD_W-1:0] wr_merged, rd_src, rd_slot;

  assign wr_nl   = lanes_of(cfg_wr_q);
  assign rd_nl   = lanes_of(cfg_rd_q);
  assign wr_segs = LANES / wr_nl;
  assign rd_segs = LANES / rd_nl;

  assign wr_last   = int'(wr_idx) == wr_segs - 1;
  assign wr_merged = asm_q | ((in_data & seg_mask(wr_nl)) << seg_shift(wr_nl, int'(wr_idx), order_q));

  assign need_fetch = rd_idx == '0;
  assign rd_last    = int'(rd_idx) == rd_segs - 1;
  assign st_rd_take = out_ready && need_fetch && st_rd_avail;
  assign rd_adv     = out_ready && (!need_fetch || st_rd_avail);
  assign rd_src     = need_fetch ? st_rd_data : hold_q;
  assign rd_slot    = (rd_src >> seg_shift(rd_nl, int'(rd_idx), order_q)) & seg_mask(rd_nl);

  assign st_wr_data = wr_out_q;
  assign st_wr_en   = wr_en_q;

  always_ff @(posedge clk) begin
    if (mst_rst) begin
      cfg_wr_q <= cfg_in_width;
      cfg_rd_q <= cfg_out_width;
      order_q  <= cfg_order;
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst || prt_rst) begin
      asm_q    <= '0;
      wr_idx   <= '0;
      wr_out_q <= '0;
      wr_en_q  <= 1'b0;
    end else begin
      wr_en_q <= in_valid && wr_last;
      if (in_valid) begin
        if (wr_last) begin
          wr_out_q <= wr_merged;
          asm_q    <= '0;
          wr_idx   <= '0;
        end else begin
          asm_q  <= wr_merged;
          wr_idx <= wr_idx + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst || prt_rst) begin
      hold_q    <= '0;
      rd_idx    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_adv;
      if (rd_adv) begin
        out_data <= rd_slot;
        if (st_rd_take) hold_q <= st_rd_data;
        rd_idx <= rd_last ? '0 : rd_idx + IDX_W'(1);
      end
    end
  end

endmodule

module bus_width_adapter_chk #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int IDX_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              mst_rst,
  input logic              prt_rst,
  input logic              in_valid,
  input logic              st_wr_en,
  input logic              out_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              st_rd_take,
  input logic              st_rd_avail,
  input logic [1:0]        cfg_wr_q,
  input logic [1:0]        cfg_rd_q,
  input logic              order_q,
  input logic [IDX_W-1:0]  wr_idx
);

  int rd_bits, wr_segs_c;
  assign rd_bits   = (cfg_rd_q == 2'b01) ? WORD_W / 2 : (cfg_rd_q == 2'b10) ? WORD_W / 4 : WORD_W;
  assign wr_segs_c = (cfg_wr_q == 2'b01) ? 2 : (cfg_wr_q == 2'b10) ? 4 : 1;

  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (mst_rst)
    !$past(mst_rst) |-> ($stable(cfg_wr_q) && $stable(cfg_rd_q) && $stable(order_q)));

  p_reset_clear_r2: assert property (@(posedge clk) disable iff (mst_rst)
    $past(mst_rst) |-> (out_data == '0 && !out_valid && !st_wr_en));

  p_commit_follows_write_r4: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    st_wr_en |-> $past(in_valid));

  p_wr_idx_bound_r4: assert property (@(posedge clk) disable iff (mst_rst)
    int'(wr_idx) < wr_segs_c);

  p_valid_follows_ready_r6: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    out_valid |-> $past(out_ready));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (mst_rst)
    (out_data >> rd_bits) == '0);

  p_no_take_unoffered_r9: assert property (@(posedge clk) disable iff (mst_rst)
    st_rd_take |-> (st_rd_avail && out_ready));

endmodule

bind bus_width_adapter bus_width_adapter_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .mst_rst(mst_rst), .prt_rst(prt_rst), .in_valid(in_valid),
  .st_wr_en(st_wr_en), .out_ready(out_ready), .out_valid(out_valid),
  .out_data(out_data), .st_rd_take(st_rd_take), .st_rd_avail(st_rd_avail),
  .cfg_wr_q(cfg_wr_q), .cfg_rd_q(cfg_rd_q), .order_q(order_q), .wr_idx(wr_idx)
);

// File: tb/bus_width_adapter_tb.sv
module bus_width_adapter_tb;
  logic        clk = 1'b0;
  logic        mst_rst = 1'b1, prt_rst = 1'b0;
  logic [1:0]  cfg_in_width = 2'b00, cfg_out_width = 2'b00;
  logic        cfg_order = 1'b0;
  logic [35:0] in_data = '0, st_rd_data = '0;
  logic        in_valid = 1'b0, st_rd_avail = 1'b0, out_ready = 1'b0;
  logic [35:0] st_wr_data, out_data;
  logic        st_wr_en, st_rd_take, out_valid;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  int lat_wr, lat_rd;
  bit lat_ord;

  always #5 clk = ~clk;

  bus_width_adapter u_dut (
    .clk(clk), .mst_rst(mst_rst), .prt_rst(prt_rst),
    .cfg_in_width(cfg_in_width), .cfg_out_width(cfg_out_width), .cfg_order(cfg_order),
    .in_data(in_data), .in_valid(in_valid), .st_wr_data(st_wr_data), .st_wr_en(st_wr_en),
    .st_rd_data(st_rd_data), .st_rd_avail(st_rd_avail), .st_rd_take(st_rd_take),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid)
  );

  function automatic int nl_of(input int code);
    return (code == 1) ? 2 : (code == 2) ? 1 : 4;
  endfunction

  function automatic logic [35:0] mask_of(input int nl);
    return (nl == 4) ? 36'hF_FFFF_FFFF : ((36'd1 << (nl * 9)) - 36'd1);
  endfunction

  function automatic int shift_of(input int nl, input int k, input bit le);
    return (le ? k : (4 / nl) - 1 - k) * nl * 9;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic master_reset(input int wr, input int rd, input bit ord);
    @(negedge clk);
    cfg_in_width = 2'(wr); cfg_out_width = 2'(rd); cfg_order = ord;
    mst_rst = 1'b1;
    repeat (2) @(negedge clk);
    mst_rst = 1'b0;
    lat_wr = wr; lat_rd = rd; lat_ord = ord;
  endtask

  task automatic write_word(input logic [35:0] w, input string req);
    int nl = nl_of(lat_wr);
    logic [35:0] m = mask_of(nl);
    for (int k = 0; k < 4 / nl; k++) begin
      in_data  = ((w >> shift_of(nl, k, lat_ord)) & m) | (36'h9_6C3A_5F17 & ~m);
      in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      if (k == 4 / nl - 1) begin
        chk(st_wr_en === 1'b1, {req, " commit"}, 36'(st_wr_en), 36'd1);
        chk(st_wr_data === w, {req, " word"}, st_wr_data, w);
      end else
        chk(st_wr_en === 1'b0, {req, " early commit"}, 36'(st_wr_en), 36'd0);
    end
  endtask

  task automatic read_word(input logic [35:0] w, input string req);
    int nl = nl_of(lat_rd);
    logic [35:0] exp;
    for (int k = 0; k < 4 / nl; k++) begin
      out_ready   = 1'b1;
      st_rd_avail = 1'b1;
      st_rd_data  = (k == 0) ? w : ~w;
      #1;
      chk(st_rd_take === (k == 0), {req, " take"}, 36'(st_rd_take), 36'(k == 0));
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0; st_rd_avail = 1'b0;
      exp = (w >> shift_of(nl, k, lat_ord)) & mask_of(nl);
      chk(out_valid === 1'b1, {req, " valid"}, 36'(out_valid), 36'd1);
      chk(out_data === exp, {req, " lane"}, out_data, exp);
    end
  endtask

  initial begin
    logic [35:0] w, prev;
    master_reset(0, 0, 1'b0);
    chk(out_data === '0, "R2 reset out_data", out_data, '0);
    chk(out_valid === 1'b0 && st_wr_en === 1'b0, "R2 reset strobes", {out_valid, st_wr_en}, '0);

    // R3 R4 R5 R6 R7: sweep of widths and orders
    for (int wr = 0; wr < 3; wr++)
      for (int rd = 0; rd < 3; rd++)
        for (int o = 0; o < 2; o++) begin
          master_reset(wr, rd, o[0]);
          for (int n = 0; n < 2; n++) begin
            w = 36'h1_2345_6789 * 36'(wr * 7 + rd * 3 + o + n * 11 + 1) ^ 36'hA_5C3F_0E1D;
            write_word(w, "R4 R5 R3 pack");
            read_word(w ^ 36'h3_0F0F_F0F0, "R6 R5 R7 unpack");
          end
        end

    // R3: code 3 acts as 36 bits
    master_reset(3, 3, 1'b1);
    write_word(36'hB_EEF0_1234, "R3 code3 write");
    read_word(36'h7_7654_3210, "R3 code3 read");

    // R1: inputs changed after reset are ignored
    master_reset(2, 1, 1'b0);
    @(negedge clk);
    cfg_in_width = 2'b00; cfg_out_width = 2'b10; cfg_order = 1'b1;
    write_word(36'h1_2233_4455, "R1 latched write");
    read_word(36'hE_DCBA_9876, "R1 latched read");

    // R8: partial reset drops half-built word, keeps config, clears out_data
    read_word(36'h5_5555_AAAA, "R8 pre");
    out_ready = 1'b1; st_rd_avail = 1'b1; st_rd_data = 36'hF_0000_0001;
    in_data = 36'h0_0000_01FF; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0; st_rd_avail = 1'b0; in_valid = 1'b0;
    prt_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    prt_rst = 1'b0;
    chk(out_data === '0, "R8 out cleared", out_data, '0);
    write_word(36'h6_789A_BCDE, "R8 fresh word");
    read_word(36'h3_1415_9265, "R8 fresh read");

    // R9: request with nothing on offer
    prev = out_data;
    out_ready = 1'b1; st_rd_avail = 1'b0;
    #1;
    chk(st_rd_take === 1'b0, "R9 no take", 36'(st_rd_take), '0);
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R9 no valid", 36'(out_valid), '0);
    chk(out_data === prev, "R9 data held", out_data, prev);

    // R2: master reset clears a non-zero output
    master_reset(0, 0, 1'b0);
    chk(out_data === '0, "R2 clear after use", out_data, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule